// File: doc/BRIEF.md
# Backpressured Pipelined Link with Two-Slot Repeaters

This block carries a stream of fixed-width flits over a long on-chip wire that has been cut into a chain of repeater stages, one clock per stage. The upstream side drives a flit together with a request strobe. The only backward signal is a stall flag. Each repeater holds at most two flits. It raises its stall flag from a flop, so the flag reaches the previous repeater one cycle after the cause. The second slot absorbs any flit that was already on the way during that lag. The link therefore never drops a flit and never needs to send one again.

A sender feeds the first repeater and watches the link's stall output. It only presents a flit in a cycle where that output is low. A receiver takes flits from the last repeater and may stall in any pattern. Every flit the sender hands over comes out exactly once, in the order it went in. With no stall, a flit spends one cycle in each stage.

Top module: `stallgo_link`

## Requirements
- R1: While and after reset, with no traffic, `snd_stall` is 0 and `rcv_req` is 0.
- R2: No repeater ever holds more than two flits. A compliant sender never presents a flit to a full repeater, and the whole link never holds more than 2×NUM_STAGES flits.
- R3: A repeater's stall flag is a flop output. It is 1 whenever the repeater holds two flits. It is 1 otherwise only if the repeater holds one flit and its downstream side stalled in the previous cycle. After the receiver has stalled long enough for the link to fill, `snd_stall` is 1.
- R4: In any cycle where `rcv_stall` is 1, `rcv_req` is 0. In any cycle where `rcv_stall` is 0 and the last repeater holds a flit, `rcv_req` is 1 and the oldest flit it holds is on `rcv_flit`.
- R5: With `rcv_stall` held at 0 and the link empty, a flit presented in cycle k appears on `rcv_flit` with `rcv_req` 1 in cycle k+NUM_STAGES.
- R6: Under any pattern of sender gaps and receiver stalls, the flits leave in the order they entered. No flit is lost and none is duplicated. While a repeater's output is stalled, its head flit does not change.
- R7: With `rcv_stall` held at 0, a sender presenting a flit every cycle never sees `snd_stall` go to 1.
- R8: With `rcv_stall` held at 1, the link accepts at least NUM_STAGES flits before the sender is blocked. No flit leaves until the stall is released.
- R9: A repeater that holds one flit and is stalled downstream still captures a flit that arrives in the same cycle, as its second entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| snd_flit | input | FLIT_W | Flit from the sender |
| snd_req | input | 1 | Sender presents a flit this cycle |
| snd_stall | output | 1 | Registered stall flag to the sender |
| rcv_flit | output | FLIT_W | Flit to the receiver |
| rcv_req | output | 1 | A flit is delivered this cycle |
| rcv_stall | input | 1 | Receiver stall flag |

## Verification
The assertions check the per-repeater rules on every cycle:
- the occupancy never overflows;
- the stall flag is high whenever a repeater is full, and never high without one of its two causes;
- the head flit holds still while a repeater's output is stalled;
- a stalled repeater holding one flit catches the flit that is already in flight.

Only the bench's scenarios can show the properties of the whole chain:
- end-to-end order, with no loss and no duplication;
- the exact latency of NUM_STAGES cycles;
- full throughput with no stall;
- the fill depth reached when the receiver blocks.

// File: rtl/stallgo_pkg.sv
package stallgo_pkg;

  localparam int SLOTS = 2;
  localparam int OCC_W = $clog2(SLOTS + 1);

  typedef logic [OCC_W-1:0] occ_t;

  localparam occ_t OCC_EMPTY = occ_t'(0);
  localparam occ_t OCC_ONE   = occ_t'(1);
  localparam occ_t OCC_FULL  = occ_t'(SLOTS);

  // occupancy after one cycle of push/pop
  function automatic occ_t occ_next(occ_t occ, logic push, logic pop);
    occ_t r;
    r = occ;
    if (push && !pop) r = occ + occ_t'(1);
    if (pop && !push) r = occ - occ_t'(1);
    return r;
  endfunction

  // registered stall request derived from next occupancy
  function automatic logic stall_rule(occ_t occ_n, logic ds_stall);
    return (occ_n == OCC_FULL) || ((occ_n == OCC_ONE) && ds_stall);
  endfunction

endpackage

// File: rtl/stallgo_fifo2.sv
module stallgo_fifo2
  import stallgo_pkg::*;
#(
  parameter int FLIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [FLIT_W-1:0] push_flit,
  input  logic              pop,
  output logic [FLIT_W-1:0] head_flit,
  output occ_t              occ,
  output occ_t              occ_n
);

  localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [FLIT_W-1:0] slot_q [SLOTS];
  logic [PTR_W-1:0]  wr_ptr_q;
  logic [PTR_W-1:0]  rd_ptr_q;
  occ_t              occ_q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                slot_q[g] <= '0;
      else if (push && (wr_ptr_q == PTR_W'(g)))  slot_q[g] <= push_flit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= OCC_EMPTY;
    end else begin
      if (push) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
      if (pop)  rd_ptr_q <= rd_ptr_q + PTR_W'(1);
      occ_q <= occ_n;
    end
  end

  assign occ_n     = occ_next(occ_q, push, pop);
  assign occ       = occ_q;
  assign head_flit = slot_q[rd_ptr_q];

endmodule

// File: rtl/stallgo_stall_gen.sv
module stallgo_stall_gen
  import stallgo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  occ_t occ_n,
  input  logic ds_stall,
  output logic stall_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= stall_rule(occ_n, ds_stall);
  end

endmodule

// File: rtl/stallgo_stage.sv
module stallgo_stage
  import stallgo_pkg::*;
#(
  parameter int FLIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLIT_W-1:0] up_flit,
  input  logic              up_req,
  output logic              up_stall,
  output logic [FLIT_W-1:0] dn_flit,
  output logic              dn_req,
  input  logic              ds_stall
);

  occ_t occ;
  occ_t occ_n;
  logic push_ev;
  logic pop_ev;
  logic full_w;
  logic empty_w;

  assign full_w  = (occ == OCC_FULL);
  assign empty_w = (occ == OCC_EMPTY);
  assign push_ev = up_req && !full_w;
  assign pop_ev  = !empty_w && !ds_stall;
  assign dn_req  = pop_ev;

  stallgo_fifo2 #(.FLIT_W(FLIT_W)) fifo_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_ev),
    .push_flit (up_flit),
    .pop       (pop_ev),
    .head_flit (dn_flit),
    .occ       (occ),
    .occ_n     (occ_n)
  );

  stallgo_stall_gen stall_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .occ_n    (occ_n),
    .ds_stall (ds_stall),
    .stall_q  (up_stall)
  );

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    up_req |-> !full_w); // R2
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_FULL); // R2
  AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full_w |-> up_stall); // R3
  AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    up_stall |-> (full_w || ((occ == OCC_ONE) && $past(ds_stall)))); // R3
  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_w && ds_stall) |=> $stable(dn_flit)); // R6
  AST_SLACK_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req && (occ == OCC_ONE) && ds_stall) |=> full_w); // R9

endmodule

// File: rtl/stallgo_link.sv
module stallgo_link #(
  parameter int FLIT_W     = 16,
  parameter int NUM_STAGES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLIT_W-1:0] snd_flit,
  input  logic              snd_req,
  output logic              snd_stall,
  output logic [FLIT_W-1:0] rcv_flit,
  output logic              rcv_req,
  input  logic              rcv_stall
);

  logic [FLIT_W-1:0] hop_flit  [NUM_STAGES+1];
  logic              hop_req   [NUM_STAGES+1];
  logic              hop_stall [NUM_STAGES+1];

  assign hop_flit[0]          = snd_flit;
  assign hop_req[0]           = snd_req;
  assign snd_stall            = hop_stall[0];
  assign hop_stall[NUM_STAGES] = rcv_stall;
  assign rcv_flit             = hop_flit[NUM_STAGES];
  assign rcv_req              = hop_req[NUM_STAGES];

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    stallgo_stage #(.FLIT_W(FLIT_W)) stage_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_flit  (hop_flit[s]),
      .up_req   (hop_req[s]),
      .up_stall (hop_stall[s]),
      .dn_flit  (hop_flit[s+1]),
      .dn_req   (hop_req[s+1]),
      .ds_stall (hop_stall[s+1])
    );
  end

  AST_RCV_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_stall |-> !rcv_req); // R4

endmodule

// File: tb/stallgo_link_tb_top.sv
`timescale 1ns/1ps
module stallgo_link_tb_top;

  localparam int W = 16;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] snd_flit = '0;
  logic         snd_req = 1'b0;
  logic         snd_stall;
  logic [W-1:0] rcv_flit;
  logic         rcv_req;
  logic         rcv_stall = 1'b0;

  always #2 clk = ~clk;

  stallgo_link #(.FLIT_W(W), .NUM_STAGES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .snd_flit(snd_flit), .snd_req(snd_req),
    .snd_stall(snd_stall), .rcv_flit(rcv_flit), .rcv_req(rcv_req),
    .rcv_stall(rcv_stall)
  );

  int n_chk = 0;
  int n_bad = 0;
  int sent_cnt = 0;
  int recv_cnt = 0;
  int cyc = 0;
  int last_rx_cyc = -1;
  logic saw_stall = 1'b0;

  // {send pattern, stall pattern, cycles}; expected result: in-order, lossless
  localparam int NVEC = 6;
  localparam logic [47:0] VEC [NVEC] = '{
    {16'hFFFF, 16'h0000, 16'd60},
    {16'hFFFF, 16'hAAAA, 16'd80},
    {16'hFFFF, 16'hF0F0, 16'd96},
    {16'h5A5A, 16'hCC33, 16'd96},
    {16'hFFFF, 16'hFFFE, 16'd120},
    {16'h9F3B, 16'h6D29, 16'd160}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic want_send, input logic stall);
    @(negedge clk);
    cyc++;
    rcv_stall = stall;
    if (want_send && !snd_stall) begin
      snd_req  = 1'b1;
      snd_flit = sent_cnt[W-1:0];
      sent_cnt++;
    end else begin
      snd_req = 1'b0;
    end
    #1;
    if (snd_stall) saw_stall = 1'b1;
    if (stall) check(!rcv_req, "R4 req while stalled", int'(rcv_req), 0);
    if (rcv_req) begin
      check(rcv_flit == recv_cnt[W-1:0], "R6 order", int'(rcv_flit), recv_cnt & 16'hFFFF);
      recv_cnt++;
      last_rx_cyc = cyc;
    end
  endtask

  task automatic drain(input int cycles);
    for (int i = 0; i < cycles; i++) tick(1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset
    repeat (3) @(negedge clk);
    check(!snd_stall, "R1 stall in reset", int'(snd_stall), 0);
    check(!rcv_req, "R1 req in reset", int'(rcv_req), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!snd_stall, "R1 stall after reset", int'(snd_stall), 0);
    check(!rcv_req, "R1 req after reset", int'(rcv_req), 0);

    // R5 latency
    tick(1'b1, 1'b0);
    begin
      int k;
      k = cyc;
      drain(N + 3);
      check(last_rx_cyc == k + N, "R5 latency", last_rx_cyc - k, N);
    end

    // R7 full throughput
    saw_stall = 1'b0;
    begin
      int s0;
      s0 = sent_cnt;
      for (int i = 0; i < 40; i++) tick(1'b1, 1'b0);
      check(!saw_stall, "R7 stall seen", int'(saw_stall), 0);
      check(sent_cnt - s0 == 40, "R7 accepted", sent_cnt - s0, 40);
    end
    drain(N + 2);
    check(recv_cnt == sent_cnt, "R6 drained after R7", recv_cnt, sent_cnt);

    // R8 / R2 / R3 fill while receiver blocks
    begin
      int s0, r0, acc;
      s0 = sent_cnt;
      r0 = recv_cnt;
      for (int i = 0; i < 40; i++) tick(1'b1, 1'b1);
      acc = sent_cnt - s0;
      check(acc >= N, "R8 fill lower bound", acc, N);
      check(acc <= 2 * N, "R2 fill upper bound", acc, 2 * N);
      check(recv_cnt == r0, "R8 no delivery while stalled", recv_cnt - r0, 0);
      check(snd_stall, "R3 stall after fill", int'(snd_stall), 1);
    end
    drain(3 * N);
    check(recv_cnt == sent_cnt, "R6 drained after fill", recv_cnt, sent_cnt);
    check(!snd_stall, "R3 stall released", int'(snd_stall), 0);

    // table walk: random-like gaps and stalls (R6, R9 slack capture)
    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] sp, tp;
      int cy;
      sp = VEC[v][47:32];
      tp = VEC[v][31:16];
      cy = int'(VEC[v][15:0]);
      for (int c = 0; c < cy; c++)
        tick(sp[c % 16], tp[(c + c / 16) % 16]);
      drain(3 * N);
      check(recv_cnt == sent_cnt, "R6/R9 lossless vector", recv_cnt, sent_cnt);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule